// File: doc/BRIEF.md
# Crystal and PLL Power Sequencer

This block brings an on-board crystal oscillator and its PLL up or down by driving two general-purpose output bits and their output enables. A request names the resources it touches through a two-bit mask and says whether they are to be powered up or down. A power-up walks through timed steps. First the crystal starts, with the PLL held in power-down. After a settling wait the PLL is released, followed by a second wait. A power-down is applied in a single update with no wait.

A clock that is already running must never glitch. The block reads back one input that shows whether the crystal is powered. The PLL power-down state cannot be read, so it is inferred from that input: when the crystal already runs, a power-up leaves the output bits alone. At the end of every power-up, the block rewrites a status register with its target-abort flag cleared and every other bit kept. A register-access error reported at any step ends the request with an error pulse instead of a done pulse.

Requests arrive on a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle. A source may hold `req_valid` high for as long as it likes. While the block is busy, nothing on the request pins has any effect.

Top module: `xpll_power_seq`

## Requirements
- R1: After reset, `gpio_out` and `gpio_oe` are 0, `req_ready` is 1, and `done`, `err` and `stat_we` are 0.
- R2: A request is accepted only when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is low from the next cycle until the request ends. Request pins driven while `req_ready` is low have no effect on `gpio_out` or on later results.
- R3: Mask bit 0 selects the crystal and mask bit 1 selects the PLL. The same positions are used in `gpio_out` and `gpio_oe`. On acceptance, in either direction, every `gpio_oe` bit selected by the mask is set. No `gpio_oe` bit is ever cleared except by reset.
- R4: A power-up (`req_on`=1) accepted while `xtal_running` is 1 leaves `gpio_out` unchanged.
- R5: A power-up with mask bit 0 set and `xtal_running` low sets `gpio_out[0]` on acceptance. In the same update it sets `gpio_out[1]` (PLL held down) if mask bit 1 is set. It then waits `XTAL_WAIT` cycles.
- R6: A power-up with mask bit 1 set and `xtal_running` low clears `gpio_out[1]` (PLL power-down is active high) after any crystal step, then waits `PLL_WAIT` cycles. A PLL-only request does this without touching `gpio_out[0]`.
- R7: Every power-up that is not aborted produces exactly one `stat_we` cycle. In that cycle `stat_wdata` equals `stat_rdata` with only bit `ABORT_BIT` forced to 0.
- R8: A power-down (`req_on`=0) clears `gpio_out[0]` if mask bit 0 is set and sets `gpio_out[1]` if mask bit 1 is set. It has no wait and never asserts `stat_we`.
- R9: `done` is a one-cycle pulse. It rises L cycles after the accepting edge, where L = 1, plus `XTAL_WAIT` if the crystal step runs, plus `PLL_WAIT`+1 if the PLL step runs.
- R10: `acc_err` high in any busy cycle ends the request. The next cycle gives a one-cycle `err` pulse, with no `done` and no further `stat_we`, and the block is then idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_on | input | 1 | 1 = power up, 0 = power down |
| req_mask | input | 2 | Bit 0 crystal, bit 1 PLL |
| xtal_running | input | 1 | Read-back: crystal is powered |
| acc_err | input | 1 | Register access failed this cycle |
| gpio_out | output | 2 | Bit 0 crystal power, bit 1 PLL power-down |
| gpio_oe | output | 2 | Output enables for `gpio_out` |
| stat_rdata | input | STAT_W | Current status register contents |
| stat_we | output | 1 | Status write strobe |
| stat_wdata | output | STAT_W | Status value to write |
| done | output | 1 | Request completed |
| err | output | 1 | Request aborted by an access error |

## Verification
A wrong state in the sequencer shows up first as a wrong `done` latency. A missing or extra wait step, or a counter off by one, moves the done pulse by a cycle, and that is visible within one request. A step decoded in the wrong order shows up in `gpio_out` during the crystal wait, where both bits must be high. A wrong branch on `xtal_running` or on the direction either changes `gpio_out` at the end of the request or adds or removes the status write. A request that slips in while the block is busy is caught when the next completed request ends with the wrong output value.

// File: rtl/xpll_pkg.sv
package xpll_pkg;
  localparam int XTAL_IDX = 0;
  localparam int PLL_IDX  = 1;
  localparam int NRES     = 2;

  typedef enum logic [2:0] {
    S_IDLE,
    S_XWAIT,
    S_PLLON,
    S_PWAIT,
    S_STAT,
    S_WR,
    S_FIN,
    S_FAIL
  } seq_state_e;
endpackage

// File: rtl/xpll_wait_timer.sv
module xpll_wait_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - W'(1);
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/xpll_gpio_regs.sv
module xpll_gpio_regs #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_m,
  input  logic [N-1:0] clr_m,
  input  logic [N-1:0] oe_m,
  output logic [N-1:0] q_out,
  output logic [N-1:0] q_oe
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_out[i] <= 1'b0;
        q_oe[i]  <= 1'b0;
      end else begin
        if (set_m[i])      q_out[i] <= 1'b1;
        else if (clr_m[i]) q_out[i] <= 1'b0;
        if (oe_m[i])       q_oe[i]  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/xpll_power_seq.sv
module xpll_power_seq
  import xpll_pkg::*;
#(
  parameter int XTAL_WAIT = 50000,
  parameter int PLL_WAIT  = 250000,
  parameter int STAT_W    = 16,
  parameter int ABORT_BIT = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_on,
  input  logic [1:0]        req_mask,
  input  logic              xtal_running,
  input  logic              acc_err,
  output logic [1:0]        gpio_out,
  output logic [1:0]        gpio_oe,
  input  logic [STAT_W-1:0] stat_rdata,
  output logic              stat_we,
  output logic [STAT_W-1:0] stat_wdata,
  output logic              done,
  output logic              err
);
  localparam int MAXW = (XTAL_WAIT > PLL_WAIT) ? XTAL_WAIT : PLL_WAIT;
  localparam int CW   = $clog2(MAXW + 1);
  localparam logic [CW-1:0] XW_LD = CW'(XTAL_WAIT - 1);
  localparam logic [CW-1:0] PW_LD = CW'(PLL_WAIT - 1);
  localparam logic [STAT_W-1:0] ABORT_M = STAT_W'(1) << ABORT_BIT;

  seq_state_e st, nxt;
  logic       pll_q;
  logic [NRES-1:0] set_m, clr_m, oe_m;
  logic       ld, expired;
  logic [CW-1:0] ld_val;
  logic       accept;

  assign accept = req_valid && (st == S_IDLE);

  always_comb begin
    nxt    = st;
    set_m  = '0;
    clr_m  = '0;
    oe_m   = '0;
    ld     = 1'b0;
    ld_val = '0;
    unique case (st)
      S_IDLE: if (req_valid) begin
        oe_m = req_mask;
        if (req_on) begin
          if (xtal_running) begin
            nxt = S_STAT;
          end else if (req_mask[XTAL_IDX]) begin
            set_m[XTAL_IDX] = 1'b1;
            set_m[PLL_IDX]  = req_mask[PLL_IDX];
            ld     = 1'b1;
            ld_val = XW_LD;
            nxt    = S_XWAIT;
          end else if (req_mask[PLL_IDX]) begin
            nxt = S_PLLON;
          end else begin
            nxt = S_STAT;
          end
        end else begin
          clr_m[XTAL_IDX] = req_mask[XTAL_IDX];
          set_m[PLL_IDX]  = req_mask[PLL_IDX];
          nxt = S_WR;
        end
      end
      S_XWAIT: begin
        if (acc_err)      nxt = S_FAIL;
        else if (expired) nxt = pll_q ? S_PLLON : S_STAT;
      end
      S_PLLON: begin
        if (acc_err) nxt = S_FAIL;
        else begin
          clr_m[PLL_IDX] = 1'b1;
          ld     = 1'b1;
          ld_val = PW_LD;
          nxt    = S_PWAIT;
        end
      end
      S_PWAIT: begin
        if (acc_err)      nxt = S_FAIL;
        else if (expired) nxt = S_STAT;
      end
      S_STAT:  nxt = acc_err ? S_FAIL : S_FIN;
      S_WR:    nxt = acc_err ? S_FAIL : S_FIN;
      S_FIN:   nxt = S_IDLE;
      S_FAIL:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      pll_q <= 1'b0;
    end else begin
      st <= nxt;
      if (accept) pll_q <= req_mask[PLL_IDX];
    end
  end

  xpll_wait_timer #(.W(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld),
    .load_val (ld_val),
    .expired  (expired)
  );

  xpll_gpio_regs #(.N(NRES)) u_gpio (
    .clk   (clk),
    .rst_n (rst_n),
    .set_m (set_m),
    .clr_m (clr_m),
    .oe_m  (oe_m),
    .q_out (gpio_out),
    .q_oe  (gpio_oe)
  );

  assign req_ready  = (st == S_IDLE);
  assign stat_we    = (st == S_STAT);
  assign stat_wdata = stat_rdata & ~ABORT_M;
  assign done       = (st == S_FIN);
  assign err        = (st == S_FAIL);
endmodule

// File: rtl/xpll_power_seq_chk.sv
module xpll_power_seq_chk #(
  parameter int STAT_W    = 16,
  parameter int ABORT_BIT = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_on,
  input logic              xtal_running,
  input logic [1:0]        gpio_out,
  input logic [1:0]        gpio_oe,
  input logic              stat_we,
  input logic [STAT_W-1:0] stat_wdata,
  input logic              done,
  input logic              err
);
  assert_ready_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_idle_holds_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> $stable(gpio_out));

  assert_oe_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> ((gpio_oe & $past(gpio_oe)) == $past(gpio_oe)));

  assert_running_untouched_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_on && xtal_running) |=> $stable(gpio_out));

  assert_abort_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |-> !stat_wdata[ABORT_BIT]);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_end_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err, stat_we}));

  assert_err_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (!err && req_ready));
endmodule

bind xpll_power_seq xpll_power_seq_chk #(.STAT_W(STAT_W), .ABORT_BIT(ABORT_BIT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_on       (req_on),
  .xtal_running (xtal_running),
  .gpio_out     (gpio_out),
  .gpio_oe      (gpio_oe),
  .stat_we      (stat_we),
  .stat_wdata   (stat_wdata),
  .done         (done),
  .err          (err)
);

// File: tb/sim_xpll_power_seq.sv
`timescale 1ns/1ps
module sim_xpll_power_seq;
  localparam int XW = 4;
  localparam int PW = 6;
  localparam int SW = 16;
  localparam int AB = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_on = 1'b0, xtal_running = 1'b0, acc_err = 1'b0;
  logic [1:0] req_mask = 2'b00;
  logic [SW-1:0] stat_rdata = '0;
  logic req_ready, stat_we, done, err;
  logic [1:0] gpio_out, gpio_oe;
  logic [SW-1:0] stat_wdata;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  xpll_power_seq #(.XTAL_WAIT(XW), .PLL_WAIT(PW), .STAT_W(SW), .ABORT_BIT(AB)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_on(req_on), .req_mask(req_mask), .xtal_running(xtal_running),
    .acc_err(acc_err), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
    .stat_rdata(stat_rdata), .stat_we(stat_we), .stat_wdata(stat_wdata),
    .done(done), .err(err)
  );

  // {on, mask[1:0], xtal_running, exp_out[1:0], exp_oe[1:0], exp_latency[4:0], exp_stat_write}
  localparam logic [13:0] VEC [0:7] = '{
    {1'b1, 2'b01, 1'b0, 2'b01, 2'b01, 5'd5,  1'b1},
    {1'b1, 2'b10, 1'b1, 2'b01, 2'b11, 5'd1,  1'b1},
    {1'b0, 2'b10, 1'b1, 2'b11, 2'b11, 5'd1,  1'b0},
    {1'b1, 2'b10, 1'b0, 2'b01, 2'b11, 5'd8,  1'b1},
    {1'b0, 2'b01, 1'b0, 2'b00, 2'b11, 5'd1,  1'b0},
    {1'b1, 2'b11, 1'b0, 2'b01, 2'b11, 5'd12, 1'b1},
    {1'b0, 2'b11, 1'b0, 2'b10, 2'b11, 5'd1,  1'b0},
    {1'b1, 2'b00, 1'b0, 2'b10, 2'b11, 5'd1,  1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_req(input logic on, input logic [1:0] m, input logic x,
                        output int lat, output logic saw_st,
                        output logic [SW-1:0] wd, output logic saw_err);
    @(negedge clk);
    req_on = on; req_mask = m; xtal_running = x; req_valid = 1'b1;
    chk("R2 ready before accept", 32'(req_ready), 32'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 ready low after accept", 32'(req_ready), 32'd0);
    lat = 0; saw_st = 1'b0; wd = '0;
    if (stat_we) begin saw_st = 1'b1; wd = stat_wdata; end
    while (!done && !err && lat < 2000) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (stat_we) begin saw_st = 1'b1; wd = stat_wdata; end
    end
    saw_err = err;
    @(negedge clk);
    chk("R9 done single cycle", 32'(done), 32'd0);
  endtask

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    logic sst, serr;
    logic [SW-1:0] wd;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset out", 32'(gpio_out), 32'd0);
    chk("R1 reset oe", 32'(gpio_oe), 32'd0);
    chk("R1 reset ready", 32'(req_ready), 32'd1);
    chk("R1 reset done/err/we", 32'({done, err, stat_we}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      logic [13:0] v;
      logic [SW-1:0] sin;
      v = VEC[i];
      sin = 16'hFFFF ^ SW'(i * 16'h1357);
      stat_rdata = sin;
      do_req(v[13], v[12:11], v[10], lat, sst, wd, serr);
      chk($sformatf("R4/R5/R6/R8 vec%0d gpio_out", i), 32'(gpio_out), 32'(v[9:8]));
      chk($sformatf("R3 vec%0d gpio_oe", i), 32'(gpio_oe), 32'(v[7:6]));
      chk($sformatf("R9 vec%0d latency", i), 32'(lat), 32'(v[5:1]));
      chk($sformatf("R7/R8 vec%0d status write seen", i), 32'(sst), 32'(v[0]));
      if (v[0])
        chk($sformatf("R7 vec%0d status value", i), 32'(wd), 32'(sin & ~(SW'(1) << AB)));
      chk($sformatf("R10 vec%0d no err", i), 32'(serr), 32'd0);
    end

    // R5: during the crystal wait, PLL stays held down alongside the crystal bit
    @(negedge clk);
    req_on = 1'b1; req_mask = 2'b11; xtal_running = 1'b0; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R5 both bits high in crystal wait", 32'(gpio_out), 32'd3);
    repeat (XW) @(negedge clk);
    chk("R5 PLL still held at end of crystal wait", 32'(gpio_out), 32'd3);
    repeat (PW + 4) @(negedge clk);
    chk("R6 PLL released", 32'(gpio_out), 32'd1);

    // R8: power everything down
    do_req(1'b0, 2'b11, 1'b0, lat, sst, wd, serr);
    chk("R8 all down", 32'(gpio_out), 32'd2);

    // R10: access error during crystal wait
    @(negedge clk);
    req_on = 1'b1; req_mask = 2'b01; xtal_running = 1'b0; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    acc_err = 1'b1;
    @(negedge clk);
    acc_err = 1'b0;
    chk("R10 err pulse", 32'(err), 32'd1);
    chk("R10 no done", 32'(done), 32'd0);
    chk("R10 crystal bit kept", 32'(gpio_out), 32'd3);
    @(negedge clk);
    chk("R10 err one cycle and idle", 32'({err, req_ready}), 32'd1);
    sst = 1'b0;
    repeat (XW + 3) begin
      @(negedge clk);
      if (stat_we || done) sst = 1'b1;
    end
    chk("R10 no later status write or done", 32'(sst), 32'd0);

    // R2: a request shown while busy is ignored
    @(negedge clk);
    req_on = 1'b1; req_mask = 2'b10; xtal_running = 1'b0; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_on = 1'b0; req_mask = 2'b11;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    for (int c = 0; c < PW + 8; c++) begin
      @(negedge clk);
      if (done) lat++;
    end
    chk("R2 busy request ignored, PLL on", 32'(gpio_out), 32'd1);
    chk("R2 exactly one done", 32'(lat), 32'd1);
    chk("R2 idle after", 32'(req_ready), 32'd1);

    // R1: reset mid-life returns everything to the reset state
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 out after reset", 32'(gpio_out), 32'd0);
    chk("R1 oe after reset", 32'(gpio_oe), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule